// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block decides, at each instruction boundary of a small 32-bit core, whether an interrupt is entered and what the architectural state becomes. Eight request sources feed it: a reset request, a non-maskable request (NMI) and six maskable lines. When the boundary strobe is high, the block chooses at most one source. In that same cycle it presents the new program counter and status word. On the closing clock edge it updates the save registers and the exception cause register.

The maskable lines and the NMI each have their own save pair, which holds the PC and PSW that were interrupted. The cause register has two halves. The upper half holds the NMI code and the lower half holds the maskable code, and each half is written without disturbing the other. An NMI that arrives while an earlier NMI is still being serviced is not taken. It leaves one deferred flag, and the block services that flag at a later quiet boundary. Status bits sit at fixed positions: interrupt-disable (ID) is bit 5, exception-pending (EP) is bit 6 and NMI-in-service (NP) is bit 7.

Top module: `irq_entry_seq`

## Requirements
- R1: While `boundary` is low, `new_pc`/`new_psw` equal `cur_pc`/`cur_psw`, and the save pairs, `cause` and `nmi_held` keep their values.
- R2: A reset request at a boundary wins over every other source. It drives `new_pc`=0 and `new_psw`=0x20, and after the edge `cause`=0 and `nmi_held`=0. The save pairs are untouched.
- R3: Every accepted NMI or maskable entry sets bit 5 (ID) and clears bit 6 (EP) of `new_psw`. Every other bit comes from `cur_psw`, except bit 7 on an NMI (see R4).
- R4: An NMI request with bit 7 (NP) of `cur_psw` clear is accepted. It drives `new_pc`=0x10 and sets bit 7 of `new_psw`, and after the edge the NMI save pair holds the incoming PC and PSW.
- R5: An accepted NMI loads 0x0010 into `cause[31:16]` and keeps `cause[15:0]`.
- R6: An accepted maskable line i (0..5) drives `new_pc`=0x80+0x10·i. After the edge, the maskable save pair holds the incoming PC and PSW, `cause[15:0]` holds that same vector and `cause[31:16]` is kept.
- R7: Maskable lines are ignored while bit 5 of `cur_psw` is set, and the outputs then follow the inputs.
- R8: Only one entry happens per boundary. An NMI request beats any maskable line, and among active lines the lowest index wins.
- R9: An NMI request while bit 7 of `cur_psw` is set is not taken. The outputs follow the inputs, the NMI save pair is kept and `nmi_held` becomes 1. Repeated requests leave a single flag.
- R10: If `nmi_held` is set and a boundary has no reset request, no NMI request and no accepted maskable line, and bit 7 of `cur_psw` is clear, the deferred NMI is entered exactly as in R4/R5 and `nmi_held` clears. If bit 7 is set, the flag stays.
- R11: The synchronous reset `rst` clears both save pairs, `cause` and `nmi_held`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block's registers |
| boundary | input | 1 | Instruction-boundary strobe |
| reset_req | input | 1 | Reset request |
| nmi_req | input | 1 | Non-maskable request |
| line_req | input | 6 | Maskable request lines, index 0 has priority |
| cur_pc | input | 32 | Current program counter |
| cur_psw | input | 32 | Current status word |
| new_pc | output | 32 | Program counter after this boundary |
| new_psw | output | 32 | Status word after this boundary |
| line_save_pc | output | 32 | PC saved by a maskable entry |
| line_save_psw | output | 32 | PSW saved by a maskable entry |
| nmi_save_pc | output | 32 | PC saved by an NMI entry |
| nmi_save_psw | output | 32 | PSW saved by an NMI entry |
| cause | output | 32 | Cause register: [31:16] NMI code, [15:0] maskable code |
| nmi_held | output | 1 | Deferred NMI flag |

## Verification
The checker verifies these on every cycle:
- the pass-through behaviour when there is no boundary;
- the reset-request outcome;
- the masking of lines by ID;
- the deferral of an NMI while NP is set;
- the halfwise cause update and the save-pair capture for accepted NMI and maskable entries.

Some properties can only be shown by the bench's scenarios. These are the lowest-index choice among several active lines, the order in which a deferred NMI is served after NP clears, and the collapse of repeated NMIs into one flag. The bench covers them with directed sequences and with random mixes of PSW states and request patterns, checked against a reference model.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    parameter int XLEN       = 32;
    parameter int HALF_W     = XLEN / 2;
    parameter int NUM_LINES  = 6;
    parameter int LINE_IDX_W = $clog2(NUM_LINES);

    parameter int PSW_ID_BIT = 5;
    parameter int PSW_EP_BIT = 6;
    parameter int PSW_NP_BIT = 7;

    parameter logic [XLEN-1:0]   RESET_PC      = '0;
    parameter logic [XLEN-1:0]   RESET_PSW     = 32'h0000_0020;
    parameter logic [XLEN-1:0]   NMI_VECTOR    = 32'h0000_0010;
    parameter logic [HALF_W-1:0] NMI_CODE      = 16'h0010;
    parameter logic [XLEN-1:0]   LINE_VEC_BASE = 32'h0000_0080;
    parameter logic [XLEN-1:0]   LINE_VEC_STEP = 32'h0000_0010;

    typedef enum logic [2:0] {
        ENTRY_NONE,
        ENTRY_RESET,
        ENTRY_NMI,
        ENTRY_NMI_HOLD,
        ENTRY_LINE
    } entry_kind_e;

    typedef struct packed {
        entry_kind_e             kind;
        logic [LINE_IDX_W-1:0]   line;
    } entry_sel_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] psw;
    } arch_pair_t;

    typedef struct packed {
        logic [HALF_W-1:0] nmi_code;
        logic [HALF_W-1:0] line_code;
    } cause_t;

    function automatic logic [XLEN-1:0] line_vector(input logic [LINE_IDX_W-1:0] idx);
        return LINE_VEC_BASE + LINE_VEC_STEP * {{(XLEN-LINE_IDX_W){1'b0}}, idx};
    endfunction
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_seq_pkg::*;
(
    input  logic                 boundary,
    input  logic                 reset_req,
    input  logic                 nmi_req,
    input  logic [NUM_LINES-1:0] line_req,
    input  logic                 psw_id,
    input  logic                 psw_np,
    input  logic                 nmi_held,
    output entry_sel_t           sel
);
    logic [LINE_IDX_W-1:0] low_idx;
    logic                  any_line;

    // Lowest active index wins: scan downward so the last hit is the lowest.
    always_comb begin
        low_idx  = '0;
        any_line = 1'b0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (line_req[i]) begin
                low_idx  = LINE_IDX_W'(i);
                any_line = 1'b1;
            end
        end
    end

    always_comb begin
        sel.kind = ENTRY_NONE;
        sel.line = low_idx;
        if (boundary) begin
            if (reset_req)
                sel.kind = ENTRY_RESET;
            else if (nmi_req)
                sel.kind = psw_np ? ENTRY_NMI_HOLD : ENTRY_NMI;
            else if (any_line && !psw_id)
                sel.kind = ENTRY_LINE;
            else if (nmi_held && !psw_np)
                sel.kind = ENTRY_NMI;
        end
    end
endmodule

// File: rtl/irq_entry_calc.sv
module irq_entry_calc
    import irq_seq_pkg::*;
(
    input  entry_sel_t       sel,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  cur_psw,
    input  cause_t           cause_q,
    input  logic             held_q,
    output logic [XLEN-1:0]  nxt_pc,
    output logic [XLEN-1:0]  nxt_psw,
    output cause_t           cause_d,
    output logic             held_d,
    output logic             line_save_en,
    output logic             nmi_save_en
);
    logic [XLEN-1:0] entry_psw;
    logic [XLEN-1:0] vec;

    always_comb begin
        entry_psw             = cur_psw;
        entry_psw[PSW_ID_BIT] = 1'b1;
        entry_psw[PSW_EP_BIT] = 1'b0;
        vec                   = line_vector(sel.line);

        nxt_pc       = cur_pc;
        nxt_psw      = cur_psw;
        cause_d      = cause_q;
        held_d       = held_q;
        line_save_en = 1'b0;
        nmi_save_en  = 1'b0;

        unique case (sel.kind)
            ENTRY_RESET: begin
                nxt_pc  = RESET_PC;
                nxt_psw = RESET_PSW;
                cause_d = '0;
                held_d  = 1'b0;
            end
            ENTRY_NMI: begin
                nxt_pc              = NMI_VECTOR;
                nxt_psw             = entry_psw;
                nxt_psw[PSW_NP_BIT] = 1'b1;
                cause_d.nmi_code    = NMI_CODE;
                held_d              = 1'b0;
                nmi_save_en         = 1'b1;
            end
            ENTRY_NMI_HOLD: begin
                held_d = 1'b1;
            end
            ENTRY_LINE: begin
                nxt_pc            = vec;
                nxt_psw           = entry_psw;
                cause_d.line_code = vec[HALF_W-1:0];
                line_save_en      = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 boundary,
    input  logic                 reset_req,
    input  logic                 nmi_req,
    input  logic [NUM_LINES-1:0] line_req,
    input  logic [XLEN-1:0]      cur_pc,
    input  logic [XLEN-1:0]      cur_psw,
    output logic [XLEN-1:0]      new_pc,
    output logic [XLEN-1:0]      new_psw,
    output logic [XLEN-1:0]      line_save_pc,
    output logic [XLEN-1:0]      line_save_psw,
    output logic [XLEN-1:0]      nmi_save_pc,
    output logic [XLEN-1:0]      nmi_save_psw,
    output logic [XLEN-1:0]      cause,
    output logic                 nmi_held
);
    entry_sel_t sel;
    cause_t     cause_q, cause_d;
    arch_pair_t line_pair_q, nmi_pair_q;
    logic       held_q, held_d;
    logic       line_save_en, nmi_save_en;

    irq_arbiter u_arb (
        .boundary (boundary),
        .reset_req(reset_req),
        .nmi_req  (nmi_req),
        .line_req (line_req),
        .psw_id   (cur_psw[PSW_ID_BIT]),
        .psw_np   (cur_psw[PSW_NP_BIT]),
        .nmi_held (held_q),
        .sel      (sel)
    );

    irq_entry_calc u_calc (
        .sel         (sel),
        .cur_pc      (cur_pc),
        .cur_psw     (cur_psw),
        .cause_q     (cause_q),
        .held_q      (held_q),
        .nxt_pc      (new_pc),
        .nxt_psw     (new_psw),
        .cause_d     (cause_d),
        .held_d      (held_d),
        .line_save_en(line_save_en),
        .nmi_save_en (nmi_save_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q     <= '0;
            held_q      <= 1'b0;
            line_pair_q <= '0;
            nmi_pair_q  <= '0;
        end else begin
            cause_q <= cause_d;
            held_q  <= held_d;
            if (line_save_en)
                line_pair_q <= '{pc: cur_pc, psw: cur_psw};
            if (nmi_save_en)
                nmi_pair_q <= '{pc: cur_pc, psw: cur_psw};
        end
    end

    assign cause         = cause_q;
    assign nmi_held      = held_q;
    assign line_save_pc  = line_pair_q.pc;
    assign line_save_psw = line_pair_q.psw;
    assign nmi_save_pc   = nmi_pair_q.pc;
    assign nmi_save_psw  = nmi_pair_q.psw;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk
    import irq_seq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 boundary,
    input logic                 reset_req,
    input logic                 nmi_req,
    input logic [NUM_LINES-1:0] line_req,
    input logic [XLEN-1:0]      cur_pc,
    input logic [XLEN-1:0]      cur_psw,
    input logic [XLEN-1:0]      new_pc,
    input logic [XLEN-1:0]      new_psw,
    input logic [XLEN-1:0]      line_save_pc,
    input logic [XLEN-1:0]      nmi_save_pc,
    input logic [XLEN-1:0]      cause,
    input logic                 nmi_held
);
    p_idle_pass_r1: assert property (@(posedge clk) disable iff (rst)
        !boundary |-> (new_pc == cur_pc) && (new_psw == cur_psw));

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(cause) && $stable(nmi_held) && $stable(line_save_pc) && $stable(nmi_save_pc));

    p_reset_entry_r2: assert property (@(posedge clk) disable iff (rst)
        boundary && reset_req |-> (new_pc == RESET_PC) && (new_psw == RESET_PSW));

    p_reset_clear_r2: assert property (@(posedge clk) disable iff (rst)
        boundary && reset_req |=> (cause == '0) && !nmi_held);

    p_nmi_save_r4: assert property (@(posedge clk) disable iff (rst)
        boundary && !reset_req && nmi_req && !cur_psw[PSW_NP_BIT]
        |=> (nmi_save_pc == $past(cur_pc)) && !nmi_held);

    p_nmi_cause_r5: assert property (@(posedge clk) disable iff (rst)
        boundary && !reset_req && nmi_req && !cur_psw[PSW_NP_BIT]
        |=> (cause[XLEN-1:HALF_W] == NMI_CODE) && (cause[HALF_W-1:0] == $past(cause[HALF_W-1:0])));

    p_line_entry_r3: assert property (@(posedge clk) disable iff (rst)
        boundary && !reset_req && !nmi_req && (|line_req) && !cur_psw[PSW_ID_BIT]
        |-> new_psw[PSW_ID_BIT] && !new_psw[PSW_EP_BIT] && (new_pc[3:0] == 4'h0));

    p_line_cause_r6: assert property (@(posedge clk) disable iff (rst)
        boundary && !reset_req && !nmi_req && (|line_req) && !cur_psw[PSW_ID_BIT]
        |=> (cause[HALF_W-1:0] == $past(new_pc[HALF_W-1:0])) && $stable(cause[XLEN-1:HALF_W])
            && (line_save_pc == $past(cur_pc)));

    p_masked_r7: assert property (@(posedge clk) disable iff (rst)
        boundary && !reset_req && !nmi_req && !nmi_held && cur_psw[PSW_ID_BIT]
        |-> (new_pc == cur_pc) && (new_psw == cur_psw));

    p_nmi_defer_r9: assert property (@(posedge clk) disable iff (rst)
        boundary && !reset_req && nmi_req && cur_psw[PSW_NP_BIT]
        |=> nmi_held && $stable(nmi_save_pc) && $stable(cause));
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (.*);

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boundary = 1'b0, reset_req = 1'b0, nmi_req = 1'b0;
    logic [5:0]  line_req = '0;
    logic [31:0] cur_pc = '0, cur_psw = '0;
    logic [31:0] new_pc, new_psw, line_save_pc, line_save_psw, nmi_save_pc, nmi_save_psw, cause;
    logic        nmi_held;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] m_cause = '0, m_lpc = '0, m_lpsw = '0, m_npc = '0, m_npsw = '0;
    logic        m_held = 1'b0;

    always #10 clk = ~clk;

    irq_entry_seq uut (
        .clk(clk), .rst(rst), .boundary(boundary), .reset_req(reset_req), .nmi_req(nmi_req),
        .line_req(line_req), .cur_pc(cur_pc), .cur_psw(cur_psw), .new_pc(new_pc), .new_psw(new_psw),
        .line_save_pc(line_save_pc), .line_save_psw(line_save_psw), .nmi_save_pc(nmi_save_pc),
        .nmi_save_psw(nmi_save_psw), .cause(cause), .nmi_held(nmi_held)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int lowest(input logic [5:0] ln);
        for (int i = 0; i < 6; i++) if (ln[i]) return i;
        return 0;
    endfunction

    task automatic check_state(input string tag);
        chk(tag, cause, m_cause);
        chk(tag, line_save_pc, m_lpc);
        chk(tag, line_save_psw, m_lpsw);
        chk(tag, nmi_save_pc, m_npc);
        chk(tag, nmi_save_psw, m_npsw);
        chk(tag, {31'b0, nmi_held}, {31'b0, m_held});
    endtask

    // kinds: 0 none, 1 reset, 2 nmi entry, 3 nmi deferred, 4 maskable line
    task automatic step(input bit s, input bit rr, input bit nr, input logic [5:0] ln,
                        input logic [31:0] pc, input logic [31:0] psw);
        int          k;
        logic [31:0] e_pc, e_psw, ent, vec;
        string       tag;
        @(negedge clk);
        boundary = s; reset_req = rr; nmi_req = nr; line_req = ln; cur_pc = pc; cur_psw = psw;
        #1;
        k = 0;
        if (s) begin
            if (rr) k = 1;
            else if (nr) k = psw[7] ? 3 : 2;
            else if ((ln != 0) && !psw[5]) k = 4;
            else if (m_held && !psw[7]) k = 2;
        end
        ent = (psw | 32'h20) & ~32'h40;
        vec = 32'h80 + 32'h10 * lowest(ln);
        e_pc = pc; e_psw = psw;
        case (k)
            1: begin e_pc = 0; e_psw = 32'h20; tag = "R2"; end
            2: begin e_pc = 32'h10; e_psw = ent | 32'h80; tag = nr ? "R4" : "R10"; end
            3: tag = "R9";
            4: begin e_pc = vec; e_psw = ent; tag = ($countones(ln) > 1) ? "R8" : "R6"; end
            default: tag = (s && ln != 0 && psw[5]) ? "R7" : "R1";
        endcase
        chk(tag, new_pc, e_pc);
        chk((k == 2 || k == 4) ? "R3" : tag, new_psw, e_psw);
        @(posedge clk);
        #1;
        case (k)
            1: begin m_cause = 0; m_held = 0; end
            2: begin m_npc = pc; m_npsw = psw; m_cause[31:16] = 16'h0010; m_held = 0; end
            3: m_held = 1;
            4: begin m_lpc = pc; m_lpsw = psw; m_cause[15:0] = vec[15:0]; end
            default: ;
        endcase
        check_state(k == 2 && nr ? "R5" : tag);
    endtask

    initial begin
        #(20 * 200000);
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        cur_psw = 32'hFFFF_FFFF;
        cur_pc  = 32'h1234_5678;
        line_req = 6'h3F; nmi_req = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check_state("R11");
        @(negedge clk);
        rst = 1'b0;
        nmi_req = 1'b0; line_req = '0;

        step(0, 0, 1, 6'h3F, 32'h100, 32'h0);             // R1: no boundary
        step(1, 0, 0, 6'b101100, 32'h200, 32'h0000_0041); // R8: lowest line (2)
        step(1, 0, 0, 6'b100000, 32'h204, 32'h0);          // R6: line 5 -> 0xD0
        step(1, 0, 0, 6'b000001, 32'h208, 32'h0);          // R6: line 0 -> 0x80
        step(1, 0, 0, 6'h3F, 32'h20C, 32'h20);             // R7: ID set
        step(1, 0, 1, 6'h3F, 32'h300, 32'h40);             // R8/R4: NMI beats lines
        step(1, 0, 1, 6'h00, 32'h304, 32'h80);             // R9: deferred
        step(1, 0, 1, 6'h00, 32'h308, 32'hA0);             // R9: repeated, one flag
        step(1, 0, 0, 6'h00, 32'h30C, 32'h80);             // R10: NP still set, stays
        step(1, 0, 0, 6'h01, 32'h310, 32'h00);             // R10: line wins first
        step(1, 0, 0, 6'h00, 32'h314, 32'h20);             // R10: deferred served
        step(1, 1, 1, 6'h3F, 32'h400, 32'hFF);             // R2: reset wins
        step(1, 0, 1, 6'h00, 32'h404, 32'h80);             // R9 again
        step(1, 1, 0, 6'h00, 32'h408, 32'h0);              // R2: clears flag

        for (int n = 0; n < 3000; n++) begin
            logic [31:0] psw;
            logic [5:0]  ln;
            psw = $urandom;
            psw[5] = ($urandom % 10) < 4;
            psw[7] = ($urandom % 2) == 1;
            ln = (($urandom % 2) == 1) ? 6'($urandom) : 6'h0;
            step(($urandom % 5) != 0, ($urandom % 20) == 0, ($urandom % 5) == 0,
                 ln, $urandom & 32'hFFFF_FFFC, psw);
        end

        @(negedge clk);
        boundary = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule